// File: doc/BRIEF.md
# Codec Register Access Request Controller

This block sits on a processor's word-addressed control bus and lets software start an access to one register inside an external audio codec. Software first stores the codec register number and, for a write, the value to send. It then writes the control word. If the request bit of that word is set, a transaction starts, and one of two interrupt lines gives a single-cycle pulse. The line depends on the direction bit: one line reports a completed write request and the other reports a read reply.

The serial link to the codec is abstracted away. Starting a request only produces the pulse. The request bit is never stored: a readback of the control word always shows it clear, while every other written bit is kept. Word indices 0, 1 and 2 hold the control word, the codec register number and the data word. Any other index is unmapped. A read of an unmapped index returns zero, a write to one is dropped, and either access raises a one-cycle error flag.

Top module: `codec_req_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, all three stored words read as zero, and both interrupt lines and the error flag are low.
- R2: A write to word index 0 with bit 0 (request) and bit 1 (direction) both set drives `irq_wr_done` high for exactly the one cycle after the write edge, and `irq_rd_reply` stays low.
- R3: A write to word index 0 with bit 0 set and bit 1 clear drives `irq_rd_reply` high for exactly the one cycle after the write edge, and `irq_wr_done` stays low.
- R4: After any write to word index 0, that word reads back with bit 0 clear and bits DATA_W-1..1 equal to the written value.
- R5: A write to word index 0 with bit 0 clear produces no pulse on either interrupt line.
- R6: Word index 1 (codec register number) and word index 2 (data word) are plain storage and read back the last value written to them.
- R7: A read strobe at a word index of 3 or above returns zero on `csr_rdata` and raises `err_pulse` for the one cycle after that edge.
- R8: A write at a word index of 3 or above changes none of the three stored words and raises `err_pulse` for the one cycle after that edge. Accesses to indices 0 to 2 never raise it.
- R9: The two interrupt lines are never high in the same cycle. Back-to-back request writes give one pulse per write, each on the line that its own direction bit selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Word index of the access |
| csr_wdata | input | DATA_W | Write data |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe, used only to flag unmapped reads |
| csr_rdata | output | DATA_W | Read data for `csr_addr` (combinational when READ_REG=0) |
| irq_wr_done | output | 1 | One-cycle pulse for a write-direction request |
| irq_rd_reply | output | 1 | One-cycle pulse for a read-direction request |
| err_pulse | output | 1 | One-cycle flag for an access to an unmapped index |

## Verification
The checker watches every cycle for four things. A request write must raise the line its direction bit selects. A write with the request bit clear must raise neither line. The stored control word must match the written one with bit 0 forced clear. An unmapped access must give the error flag, and the flag must never appear without one. Readback values, such as zero from an unmapped index, a dropped unmapped write, and codec registers holding their last value, depend on the sequence of accesses. Only the bench's directed scenarios show these, as do the exact single-cycle width of each pulse and the pulse count across back-to-back requests.

// File: rtl/codec_req_pkg.sv
package codec_req_pkg;
   localparam int CTRL_REQ_BIT = 0;
   localparam int CTRL_DIR_BIT = 1;

   localparam int IDX_CTRL  = 0;
   localparam int IDX_CADDR = 1;
   localparam int IDX_CDATA = 2;
   localparam int NUM_MAPPED = 3;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_CADDR = 2'd2,
      SEL_CDATA = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/codec_req_decode.sv
module codec_req_decode
   import codec_req_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   always_comb begin
      if (addr == ADDR_W'(IDX_CTRL))       sel = SEL_CTRL;
      else if (addr == ADDR_W'(IDX_CADDR)) sel = SEL_CADDR;
      else if (addr == ADDR_W'(IDX_CDATA)) sel = SEL_CDATA;
      else                                 sel = SEL_NONE;
   end
endmodule

// File: rtl/codec_req_regfile.sv
module codec_req_regfile
   import codec_req_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] caddr_q,
   output logic [DATA_W-1:0] cdata_q
);
   localparam logic [DATA_W-1:0] REQ_MASK = ~(DATA_W'(1) << CTRL_REQ_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         caddr_q <= '0;
         cdata_q <= '0;
      end else if (we) begin
         case (sel)
            SEL_CTRL:  ctrl_q  <= wdata & REQ_MASK;
            SEL_CADDR: caddr_q <= wdata;
            SEL_CDATA: cdata_q <= wdata;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/codec_req_irq.sv
module codec_req_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic req,
   input  logic dir_wr,
   input  logic bad_access,
   output logic irq_wr_done,
   output logic irq_rd_reply,
   output logic err_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_wr_done  <= 1'b0;
         irq_rd_reply <= 1'b0;
         err_pulse    <= 1'b0;
      end else begin
         irq_wr_done  <= ctrl_wr && req && dir_wr;
         irq_rd_reply <= ctrl_wr && req && !dir_wr;
         err_pulse    <= bad_access;
      end
   end
endmodule

// File: rtl/codec_req_rdmux.sv
module codec_req_rdmux
   import codec_req_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic [DATA_W-1:0] caddr_q,
   input  logic [DATA_W-1:0] cdata_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mux_d;

   always_comb begin
      case (sel)
         SEL_CTRL:  mux_d = ctrl_q;
         SEL_CADDR: mux_d = caddr_q;
         SEL_CDATA: mux_d = cdata_q;
         default:   mux_d = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mux_d;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata = mux_d;
      end
   endgenerate
endmodule

// File: rtl/codec_req_ctrl.sv
module codec_req_ctrl
   import codec_req_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [DATA_W-1:0] csr_wdata,
   input  logic              csr_we,
   input  logic              csr_re,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              irq_wr_done,
   output logic              irq_rd_reply,
   output logic              err_pulse
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must hold the request and direction bits");
      end
      if ((2 ** ADDR_W) < NUM_MAPPED) begin : g_bad_addr_w
         $error("ADDR_W too narrow for the mapped words");
      end
   endgenerate

   reg_sel_e          sel;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] caddr_q;
   logic [DATA_W-1:0] cdata_q;
   logic              ctrl_wr;
   logic              bad_access;

   assign ctrl_wr    = csr_we && (sel == SEL_CTRL);
   assign bad_access = (csr_we || csr_re) && (sel == SEL_NONE);

   codec_req_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (csr_addr),
      .sel  (sel)
   );

   codec_req_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (csr_we),
      .sel     (sel),
      .wdata   (csr_wdata),
      .ctrl_q  (ctrl_q),
      .caddr_q (caddr_q),
      .cdata_q (cdata_q)
   );

   codec_req_irq u_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .req          (csr_wdata[CTRL_REQ_BIT]),
      .dir_wr       (csr_wdata[CTRL_DIR_BIT]),
      .bad_access   (bad_access),
      .irq_wr_done  (irq_wr_done),
      .irq_rd_reply (irq_rd_reply),
      .err_pulse    (err_pulse)
   );

   codec_req_rdmux #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .ctrl_q  (ctrl_q),
      .caddr_q (caddr_q),
      .cdata_q (cdata_q),
      .rdata   (csr_rdata)
   );
endmodule

// File: rtl/codec_req_ctrl_chk.sv
module codec_req_ctrl_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [DATA_W-1:0] csr_wdata,
   input logic              csr_we,
   input logic              csr_re,
   input logic [DATA_W-1:0] ctrl_q,
   input logic              irq_wr_done,
   input logic              irq_rd_reply,
   input logic              err_pulse
);
   logic ctrl_hit;
   logic unmapped;
   assign ctrl_hit = csr_we && (csr_addr == '0);
   assign unmapped = (csr_addr >= ADDR_W'(3));

   assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && csr_wdata[0] && csr_wdata[1]) |=> (irq_wr_done && !irq_rd_reply));

   assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && csr_wdata[0] && !csr_wdata[1]) |=> (irq_rd_reply && !irq_wr_done));

   assert_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (!ctrl_q[0] && (ctrl_q[DATA_W-1:1] == $past(csr_wdata[DATA_W-1:1]))));

   assert_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && !csr_wdata[0]) |=> (!irq_wr_done && !irq_rd_reply));

   assert_err_on_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_we || csr_re) && unmapped) |=> err_pulse);

   assert_err_only_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_we || csr_re) && !unmapped) |=> !err_pulse);

   assert_one_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_wr_done && irq_rd_reply));
endmodule

bind codec_req_ctrl codec_req_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_addr     (csr_addr),
   .csr_wdata    (csr_wdata),
   .csr_we       (csr_we),
   .csr_re       (csr_re),
   .ctrl_q       (ctrl_q),
   .irq_wr_done  (irq_wr_done),
   .irq_rd_reply (irq_rd_reply),
   .err_pulse    (err_pulse)
);

// File: tb/codec_req_ctrl_tb.sv
module codec_req_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] csr_addr = '0;
   logic [DW-1:0] csr_wdata = '0;
   logic          csr_we = 1'b0;
   logic          csr_re = 1'b0;
   logic [DW-1:0] csr_rdata;
   logic          irq_wr_done, irq_rd_reply, err_pulse;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   codec_req_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata),
      .irq_wr_done(irq_wr_done), .irq_rd_reply(irq_rd_reply), .err_pulse(err_pulse)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge, inside the cycle after the write edge.
   task automatic csr_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   // Returns combinational read data; ends one negedge later with err_pulse visible.
   task automatic csr_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      csr_addr = a; csr_re = 1'b1;
      #1 d = csr_rdata;
      @(negedge clk);
      csr_re = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      chk("R1 irq_wr_done in reset", DW'(irq_wr_done), '0);
      chk("R1 irq_rd_reply in reset", DW'(irq_rd_reply), '0);
      chk("R1 err in reset", DW'(err_pulse), '0);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         peek(AW'(i), v);
         chk("R1 word after reset", v, '0);
      end
      chk("R1 err after reset", DW'(err_pulse), '0);
   endtask

   task automatic t_write_request();
      logic [DW-1:0] v;
      csr_write(AW'(0), 32'hA5A5_0003);
      chk("R2 irq_wr_done pulse", DW'(irq_wr_done), 1);
      chk("R2 irq_rd_reply quiet", DW'(irq_rd_reply), 0);
      peek(AW'(0), v);
      chk("R4 ctrl readback after write req", v, 32'hA5A5_0002);
      @(negedge clk);
      chk("R2 pulse one cycle", DW'(irq_wr_done), 0);
   endtask

   task automatic t_read_request();
      logic [DW-1:0] v;
      csr_write(AW'(0), 32'h0000_0F01);
      chk("R3 irq_rd_reply pulse", DW'(irq_rd_reply), 1);
      chk("R3 irq_wr_done quiet", DW'(irq_wr_done), 0);
      peek(AW'(0), v);
      chk("R4 ctrl readback after read req", v, 32'h0000_0F00);
      @(negedge clk);
      chk("R3 pulse one cycle", DW'(irq_rd_reply), 0);
   endtask

   task automatic t_no_request();
      logic [DW-1:0] v;
      csr_write(AW'(0), 32'hFFFF_FFFE);
      chk("R5 no wr pulse", DW'(irq_wr_done), 0);
      chk("R5 no rd pulse", DW'(irq_rd_reply), 0);
      peek(AW'(0), v);
      chk("R4 ctrl keeps upper bits", v, 32'hFFFF_FFFE);
   endtask

   task automatic t_codec_regs();
      logic [DW-1:0] v;
      csr_write(AW'(1), 32'h0000_002C);
      csr_write(AW'(2), 32'hDEAD_BEEF);
      csr_read(AW'(1), v);
      chk("R6 codec addr readback", v, 32'h0000_002C);
      chk("R8 no err on mapped read", DW'(err_pulse), 0);
      csr_read(AW'(2), v);
      chk("R6 codec data readback", v, 32'hDEAD_BEEF);
      csr_write(AW'(2), 32'h1234_5678);
      csr_read(AW'(2), v);
      chk("R6 codec data overwritten", v, 32'h1234_5678);
   endtask

   task automatic t_unmapped_read();
      logic [DW-1:0] v;
      csr_read(AW'(3), v);
      chk("R7 unmapped read zero", v, '0);
      chk("R7 err pulse on read", DW'(err_pulse), 1);
      @(negedge clk);
      chk("R7 err one cycle", DW'(err_pulse), 0);
      csr_read(AW'(15), v);
      chk("R7 top index reads zero", v, '0);
   endtask

   task automatic t_unmapped_write();
      logic [DW-1:0] v;
      csr_write(AW'(4), 32'hFFFF_FFFF);
      chk("R8 err pulse on write", DW'(err_pulse), 1);
      chk("R8 no irq from unmapped", DW'(irq_wr_done | irq_rd_reply), 0);
      peek(AW'(0), v); chk("R8 ctrl untouched", v, 32'hFFFF_FFFE);
      peek(AW'(1), v); chk("R8 caddr untouched", v, 32'h0000_002C);
      peek(AW'(2), v); chk("R8 cdata untouched", v, 32'h1234_5678);
   endtask

   task automatic t_back_to_back();
      int nwr = 0;
      int nrd = 0;
      csr_addr = '0; csr_wdata = 32'h3; csr_we = 1'b1;
      @(negedge clk);
      csr_wdata = 32'h1;
      chk("R9 first pulse on wr line", DW'({irq_wr_done, irq_rd_reply}), 2'b10);
      nwr += int'(irq_wr_done); nrd += int'(irq_rd_reply);
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
      chk("R9 second pulse on rd line", DW'({irq_wr_done, irq_rd_reply}), 2'b01);
      nwr += int'(irq_wr_done); nrd += int'(irq_rd_reply);
      @(negedge clk);
      nwr += int'(irq_wr_done); nrd += int'(irq_rd_reply);
      chk("R9 one wr pulse total", DW'(nwr), 1);
      chk("R9 one rd pulse total", DW'(nrd), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_write_request();
      t_read_request();
      t_no_request();
      t_codec_regs();
      t_unmapped_read();
      t_unmapped_write();
      t_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule